// File: doc/BRIEF.md
# Memory Power-Up Latency Sequencer

This block brings an external dword-oriented memory out of power-on or reset before any user traffic reaches it. While the block's own synchronous reset is asserted it holds the memory's active-low reset pin low. After reset is released it counts out the mandatory 150 µs settling interval, with the cycle count derived from the core clock frequency. When that interval ends it samples a mode strap. In default mode it issues nothing. In fast mode it issues exactly one register-space write that programs configuration register 0 for a shorter fixed latency.

The block also owns the two latency counts (single and doubled) that the memory controller uses, and it keeps them in step with the memory. In default mode they stay at the slow values the memory has after reset. In fast mode they change only once the controller has accepted the configuration write and dropped busy, and they change in the same cycle that `done` rises. The controller and the memory therefore never use different latencies while traffic is allowed. `done` tells the user side that traffic may start, and it stays high until the next reset.

Top module: `hr_init_seq`

## Requirements
- R1: `mem_rst_n` is low in every cycle in which `rst_n` is low, and high whenever `rst_n` is high.
- R2: During the first WAIT_CYCLES clock edges after reset is released (WAIT_CYCLES = CLK_HZ/1e6 × SETTLE_US, 15000 by default), `cfg_wr_req` and `done` both stay low.
- R3: The mode strap `fast_mode` is sampled only in the cycle in which the settling interval ends. If it is 0 there, no request is ever issued and `done` rises after edge WAIT_CYCLES+1.
- R4: In fast mode, exactly one request is issued, lasting one cycle and first visible after edge WAIT_CYCLES+1. While it is high, `cfg_reg_sel`=1, `cfg_addr`=0x00000800, `cfg_wr_data`=0x8FE40000 and `cfg_byte_en`=0xF. Outside the request these four outputs read 0.
- R5: A request is raised only in a cycle in which `cfg_busy` is low. While busy stays high the request is held off, and it is issued once busy falls.
- R6: From reset onward, `lat_1x`=0x12 and `lat_2x`=0x16. In default mode they keep these values after `done`.
- R7: In fast mode, the latency outputs keep their default values until the first edge at which the sequencer sees `cfg_busy` low after busy rose for the write. From that edge they read `lat_1x`=0x04 and `lat_2x`=0x0A, and `done` rises at the same edge.
- R8: Once `done` is high it stays high until reset. After that point changes on `fast_mode` or `cfg_busy` do not alter the latency outputs and raise no request.
- R9: A reset at any point, including during settling or after a fast sequence, restores the latency outputs to their defaults, clears `done` and restarts the full settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_mode | input | 1 | Mode strap: 1 programs the short latency |
| mem_rst_n | output | 1 | Active-low reset to the memory device |
| cfg_wr_req | output | 1 | One-cycle write request to the controller |
| cfg_reg_sel | output | 1 | Register-space select during the request |
| cfg_addr | output | 32 | Byte address of the request |
| cfg_wr_data | output | 32 | Write data of the request |
| cfg_byte_en | output | 4 | Byte enables of the request |
| cfg_busy | input | 1 | Controller busy indication |
| lat_1x | output | 8 | Single-latency count for the controller |
| lat_2x | output | 8 | Doubled-latency count for the controller |
| done | output | 1 | Initialisation complete, user traffic may start |

## Verification
On every cycle the assertions check the following: a request never comes before the settling interval has run out, a request never lasts a second cycle, `done` never falls without a reset, and the latency outputs move only in the cycle `done` rises. Only the bench scenarios can show the exact edge counts: the cycle at which `done` and the request first appear, and the number of cycles between the busy drop and the latency switch. The bench scenarios also show the request payload values, the hold-off under a stuck-busy controller, the strap being ignored before and after its sampling point, and recovery from a reset in the middle of settling.

// File: rtl/hr_init_pkg.sv
// Package: shared types for the memory power-up sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package hr_init_pkg;

    // Sequencer phases, in the order they are visited
    typedef enum logic [2:0] {
        ST_SETTLE    = 3'd0,
        ST_ISSUE     = 3'd1,
        ST_WAIT_BUSY = 3'd2,
        ST_DRAIN     = 3'd3,
        ST_DONE      = 3'd4
    } seq_state_t;

    localparam int LAT_LANES = 2;   // lane 0: single latency, lane 1: doubled

endpackage

// File: rtl/hr_init_settle_timer.sv
// Module: settle timer.
// Counts core clock edges after reset release and flags when the settling
// interval has elapsed. Saturates at the limit, so the flag stays high until
// the next reset. Assumes WAIT_CYCLES >= 1.
module hr_init_settle_timer #(
    parameter int WAIT_CYCLES = 15000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired_o
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: saturating edge counter, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIMIT);

    // R2: once elapsed, the interval stays elapsed until reset
    assert_expire_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> expired_o);

endmodule

// File: rtl/hr_init_cfg_fsm.sv
// Module: configuration sequencer FSM.
// Waits for the settle timer, samples the mode strap once, optionally issues
// a single write request and tracks the controller's busy until the write
// has drained. Assumes the controller raises busy within a few cycles of an
// accepted request and eventually lowers it.
module hr_init_cfg_fsm
    import hr_init_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expired_i,
    input  logic fast_i,
    input  logic busy_i,
    output logic req_o,
    output logic apply_o,
    output logic done_o
);
    seq_state_t state_q, state_d;

    // Purpose: next-phase selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE:    if (expired_i) state_d = fast_i ? ST_ISSUE : ST_DONE;
            ST_ISSUE:     if (!busy_i)   state_d = ST_WAIT_BUSY;
            ST_WAIT_BUSY: if (busy_i)    state_d = ST_DRAIN;
            ST_DRAIN:     if (!busy_i)   state_d = ST_DONE;
            ST_DONE:                     state_d = ST_DONE;
            default:                     state_d = ST_SETTLE;
        endcase
    end

    // Purpose: phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_o   = (state_q == ST_ISSUE) && !busy_i;
    assign apply_o = (state_q == ST_DRAIN) && !busy_i;
    assign done_o  = (state_q == ST_DONE);

    // R2: no request before settling has elapsed
    assert_req_after_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> expired_i);
    // R4: a request lasts a single cycle
    assert_single_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R8: done is sticky and no request follows it
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);
    assert_no_req_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_o);

endmodule

// File: rtl/hr_init_lat_reg.sv
// Module: latency count register.
// Holds the controller's latency counts, one lane per latency kind. Loads
// the default pair on reset and the fast pair on an apply pulse. Assumes
// apply is pulsed at most once per reset.
module hr_init_lat_reg
    import hr_init_pkg::*;
#(
    parameter logic [7:0] DEF_1X  = 8'h12,
    parameter logic [7:0] DEF_2X  = 8'h16,
    parameter logic [7:0] FAST_1X = 8'h04,
    parameter logic [7:0] FAST_2X = 8'h0A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply_i,
    output logic [7:0] lat_1x_o,
    output logic [7:0] lat_2x_o
);
    localparam logic [7:0] DEF_V  [LAT_LANES] = '{DEF_1X, DEF_2X};
    localparam logic [7:0] FAST_V [LAT_LANES] = '{FAST_1X, FAST_2X};

    logic [7:0] lat_q [LAT_LANES];

    for (genvar g = 0; g < LAT_LANES; g++) begin : g_lane
        // Purpose: per-lane latency value, default on reset, fast on apply
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q[g] <= DEF_V[g];
            end else if (apply_i) begin
                lat_q[g] <= FAST_V[g];
            end
        end
    end

    assign lat_1x_o = lat_q[0];
    assign lat_2x_o = lat_q[1];

    // R6/R7: the pair is always either the default or the fast setting
    assert_lat_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_1x_o == DEF_1X && lat_2x_o == DEF_2X) ||
        (lat_1x_o == FAST_1X && lat_2x_o == FAST_2X));

endmodule

// File: rtl/hr_init_seq.sv
// Module: memory power-up latency sequencer (top).
// Holds the memory in reset, waits the settling interval, optionally writes
// configuration register 0 for short latency, and switches the controller's
// latency counts in step with that write. Assumes one controller that
// accepts a one-cycle request while not busy.
module hr_init_seq #(
    parameter int          CLK_HZ    = 100_000_000,
    parameter int          SETTLE_US = 150,
    parameter logic [31:0] CFG_ADDR  = 32'h0000_0800,
    parameter logic [31:0] CFG_VALUE = 32'h8FE4_0000,
    parameter logic [7:0]  DEF_1X    = 8'h12,
    parameter logic [7:0]  DEF_2X    = 8'h16,
    parameter logic [7:0]  FAST_1X   = 8'h04,
    parameter logic [7:0]  FAST_2X   = 8'h0A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_mode,
    output logic        mem_rst_n,
    output logic        cfg_wr_req,
    output logic        cfg_reg_sel,
    output logic [31:0] cfg_addr,
    output logic [31:0] cfg_wr_data,
    output logic [3:0]  cfg_byte_en,
    input  logic        cfg_busy,
    output logic [7:0]  lat_1x,
    output logic [7:0]  lat_2x,
    output logic        done
);
    localparam int WAIT_CYCLES = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic expired;
    logic apply;

    hr_init_settle_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .expired_o (expired)
    );

    hr_init_cfg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .expired_i (expired),
        .fast_i    (fast_mode),
        .busy_i    (cfg_busy),
        .req_o     (cfg_wr_req),
        .apply_o   (apply),
        .done_o    (done)
    );

    hr_init_lat_reg #(
        .DEF_1X (DEF_1X), .DEF_2X (DEF_2X),
        .FAST_1X(FAST_1X), .FAST_2X(FAST_2X)
    ) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply_i  (apply),
        .lat_1x_o (lat_1x),
        .lat_2x_o (lat_2x)
    );

    // Purpose: memory reset follows the block reset without delay
    assign mem_rst_n = rst_n;

    // Purpose: request payload, driven only while the request is up
    assign cfg_reg_sel = cfg_wr_req;
    assign cfg_addr    = cfg_wr_req ? CFG_ADDR  : 32'h0;
    assign cfg_wr_data = cfg_wr_req ? CFG_VALUE : 32'h0;
    assign cfg_byte_en = cfg_wr_req ? 4'hF      : 4'h0;

    // R7: latency outputs move only in the cycle done rises
    assert_lat_moves_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lat_1x) || !$stable(lat_2x)) |-> $rose(done));

endmodule

// File: tb/hr_init_seq_tb.sv
module hr_init_seq_tb;
    localparam int W = 15000;   // settle cycles at 100 MHz, 150 us
    localparam int L = 4;       // busy length of the controller model

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_mode = 1'b0;
    logic        mem_rst_n, cfg_wr_req, cfg_reg_sel, done;
    logic [31:0] cfg_addr, cfg_wr_data;
    logic [3:0]  cfg_byte_en;
    logic        cfg_busy;
    logic [7:0]  lat_1x, lat_2x;

    int tests = 0;
    int fails = 0;
    logic [68:0] exp_q[$];      // {reg_sel, addr, data, byte_en}

    logic       hold_busy = 1'b0;
    int         busy_cnt = 0;

    always #5 clk = ~clk;

    hr_init_seq u_dut (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .mem_rst_n(mem_rst_n),
        .cfg_wr_req(cfg_wr_req), .cfg_reg_sel(cfg_reg_sel), .cfg_addr(cfg_addr),
        .cfg_wr_data(cfg_wr_data), .cfg_byte_en(cfg_byte_en), .cfg_busy(cfg_busy),
        .lat_1x(lat_1x), .lat_2x(lat_2x), .done(done)
    );

    // Controller model: busy for L cycles after an accepted request
    assign cfg_busy = (busy_cnt != 0) || hold_busy;
    always @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (cfg_wr_req && !cfg_busy) busy_cnt <= L;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: pops an expected request each time one appears
    always @(negedge clk) begin
        if (rst_n && cfg_wr_req === 1'b1) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected request: got %0h expected none",
                         {cfg_reg_sel, cfg_addr, cfg_wr_data, cfg_byte_en});
            end else begin
                logic [68:0] e;
                e = exp_q.pop_front();
                if ({cfg_reg_sel, cfg_addr, cfg_wr_data, cfg_byte_en} !== e) begin
                    fails++;
                    $display("FAIL R4 payload: got %0h expected %0h",
                             {cfg_reg_sel, cfg_addr, cfg_wr_data, cfg_byte_en}, e);
                end
            end
        end
    end

    task automatic push_cfg_write();
        exp_q.push_back({1'b1, 32'h0000_0800, 32'h8FE4_0000, 4'hF});
    endtask

    task automatic reset_phase(input string tag);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " R1 mem reset low"}, mem_rst_n, 0);
        chk({tag, " R9 done cleared"}, done, 0);
        chk({tag, " R9 lat default"}, {lat_1x, lat_2x}, 16'h1216);
        chk({tag, " R4 no payload idle"}, {cfg_reg_sel, cfg_addr, cfg_wr_data, cfg_byte_en}, 0);
    endtask

    // Release reset and walk the settle interval; strap flips halfway
    task automatic settle(input bit fast_final);
        int bad = 0;
        fast_mode = !fast_final;
        rst_n = 1'b1;           // at a negedge, first edge seen is E1
        for (int n = 1; n <= W; n++) begin
            @(negedge clk);
            if (n == W / 2) fast_mode = fast_final;
            if (cfg_wr_req !== 1'b0 || done !== 1'b0 || mem_rst_n !== 1'b1) bad++;
        end
        chk("R2 quiet during settling (violations)", bad, 0);
    endtask

    task automatic after_done_idle(input logic [15:0] lat_exp);
        for (int k = 0; k < 6; k++) begin
            fast_mode = ~fast_mode;
            hold_busy = k[0];
            @(negedge clk);
        end
        hold_busy = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 done stays high", done, 1);
        chk("R8 lat unchanged", {lat_1x, lat_2x}, lat_exp);
        chk("R1 mem reset released", mem_rst_n, 1);
    endtask

    task automatic fast_tail();
        repeat (L + 1) @(negedge clk);
        chk("R7 lat still default while draining", {lat_1x, lat_2x}, 16'h1216);
        chk("R7 done low while draining", done, 0);
        @(negedge clk);
        chk("R7 lat fast after busy drop", {lat_1x, lat_2x}, 16'h040A);
        chk("R7 done with lat switch", done, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // Default mode run
        reset_phase("init");
        settle(1'b0);
        @(negedge clk);         // after edge W+1
        chk("R3 done after settle in default mode", done, 1);
        chk("R6 lat default after done", {lat_1x, lat_2x}, 16'h1216);
        chk("R3 no request in default mode", cfg_wr_req, 0);
        after_done_idle(16'h1216);

        // Reset in the middle of settling restarts the interval
        reset_phase("after default");
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        reset_phase("mid settle");

        // Fast mode run
        push_cfg_write();
        settle(1'b1);
        @(negedge clk);         // after edge W+1: request visible
        chk("R4 request after settle", cfg_wr_req, 1);
        chk("R7 lat default at request", {lat_1x, lat_2x}, 16'h1216);
        fast_tail();
        chk("R4 exactly one request", exp_q.size(), 0);
        after_done_idle(16'h040A);

        // Fast mode with the controller held busy
        reset_phase("after fast");
        hold_busy = 1'b1;
        push_cfg_write();
        settle(1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R5 request held off while busy", cfg_wr_req, 0);
        end
        @(posedge clk); #1 hold_busy = 1'b0;
        @(negedge clk);
        chk("R5 request once busy drops", cfg_wr_req, 1);
        fast_tail();
        chk("R4 exactly one request after hold", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule